// File: doc/BRIEF.md
# SDRAM Gapless Read Burst Scheduler

This block sits on the controller side of a pipelined SDRAM and turns a stream of read requests into READ commands, placed so that the returned data flows without idle cycles. Each request names a bank, a column, a tag and how many of the four burst words it wants. A request that wants fewer than four words lets the next READ go out early. The newer burst then cuts off the older one, which takes the place of an explicit burst-stop command. All rows are assumed to be open already.

The block captures the data lines a programmable CAS latency after each READ. It presents every wanted word with the tag of its request and its position within the burst. The next READ leaves the block exactly as many cycles after the previous one as that previous request wanted words. The first word of each burst therefore lands on the cycle after the last wanted word of the burst before it. This holds for every latency setting and for any mix of banks, including single-word reads on every cycle.

Top module: `rd_burst_sched`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, the command lines carry NOP, `req_ready` is 1 and `rd_valid` is 0.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. In the next cycle, `{mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}` is 4'b0101 (READ), and `mem_bank` and `mem_addr` carry that request's bank and column. Every other cycle carries 4'b0111 (NOP).
- R3: `req_len` holds the number of wanted words minus one (0 to 3). After a request with value L is accepted, `req_ready` is 0 for the next L cycles and then returns to 1. With L = 0, one READ may go out on every cycle.
- R4: The word on `dq_in` in the cycle that comes CL cycles after a READ command cycle is that burst's first word. It appears on `rd_data` in the following cycle with `rd_valid` = 1 and `rd_beat` = 0.
- R5: Beats 0 to L of a request are reported in order on consecutive cycles, each with the request's tag and its beat index. Words the memory sends after beat L are never reported, whether the next burst overrides them or the bus goes idle.
- R6: When requests are offered back to back, the reported words form one stream with no idle cycle from the first word to the last. This holds for every CL value and for any sequence of banks.
- R7: `mem_dqm` is 0 in every cycle.
- R8: `cas_lat` selects a latency of 1, 2 or 3 cycles. The value 0 is illegal. The input may change only after every accepted read has delivered all of its wanted words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat | input | 2 | CAS latency in cycles, 1 to 3 |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request will be accepted this cycle |
| req_bank | input | 2 | Target bank |
| req_col | input | 8 | Starting column |
| req_tag | input | 4 | Identifier returned with the data |
| req_len | input | 2 | Wanted words minus one |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bank | output | 2 | Bank of the current READ |
| mem_addr | output | 8 | Column of the current READ |
| mem_dqm | output | 1 | Data mask, held low |
| dq_in | input | 8 | Data returned by the memory |
| rd_valid | output | 1 | Captured word present |
| rd_data | output | 8 | Captured word |
| rd_tag | output | 4 | Tag of the request the word belongs to |
| rd_beat | output | 2 | Position of the word within its burst |

## Verification
A fixed sequence of requests is replayed at each of the three latency settings. Full four-word bursts test whether the spacing matches the burst exactly. Runs of single-word reads, with adjacent reads in the same or different banks, test whether a READ can go out on every cycle. Two- and three-word requests followed by a full burst test whether truncation cuts the older burst at the right word.

The bench models the memory so that it drives all four words of every burst. A truncated request left at the end of a group then shows whether any word past the wanted length leaks out. A directed run of three-word requests pins down the shape of the `req_ready` pulse. Each reported word is checked for its cycle, data, tag and beat, which separates a wrong latency tap from a gap or from a misattributed word.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int RBS_BURST  = 4;
  localparam int RBS_MAX_CL = 3;
  localparam int RBS_LEN_W  = $clog2(RBS_BURST);
  localparam int RBS_CL_W   = $clog2(RBS_MAX_CL + 1);

  // Order of bits: chip select, row strobe, column strobe, write enable
  typedef enum logic [3:0] {
    CMD_READ = 4'b0101,
    CMD_NOP  = 4'b0111
  } rbs_cmd_e;
endpackage

// File: rtl/rbs_issue.sv
module rbs_issue
  import rbs_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int TAG_W  = 4,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  output rbs_cmd_e          cmd_q,
  output logic [BANK_W-1:0] bank_q,
  output logic [COL_W-1:0]  col_q,
  output logic              new_vld,
  output logic [TAG_W-1:0]  new_tag,
  output logic [LEN_W-1:0]  new_len
);
  logic [LEN_W-1:0] hold_q, hold_d;
  rbs_cmd_e         cmd_d;
  logic             fire;

  assign req_ready = (hold_q == '0);
  assign fire      = req_valid && req_ready;
  assign new_vld   = (cmd_q == CMD_READ);

  // Spacing counter: next READ waits as many cycles as words wanted
  always_comb begin
    hold_d = hold_q;
    if (fire)
      hold_d = req_len;
    else if (hold_q != '0)
      hold_d = hold_q - 1'b1;
    cmd_d = fire ? CMD_READ : CMD_NOP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      cmd_q   <= CMD_NOP;
      bank_q  <= '0;
      col_q   <= '0;
      new_tag <= '0;
      new_len <= '0;
    end else begin
      hold_q <= hold_d;
      cmd_q  <= cmd_d;
      if (fire) begin
        bank_q  <= req_bank;
        col_q   <= req_col;
        new_tag <= req_tag;
        new_len <= req_len;
      end
    end
  end
endmodule

// File: rtl/rbs_lat_pipe.sv
module rbs_lat_pipe #(
  parameter int TAG_W = 4,
  parameter int LEN_W = 2,
  parameter int DEPTH = 3,
  parameter int CL_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [LEN_W-1:0] in_len,
  input  logic [CL_W-1:0]  sel,
  output logic             arr_vld,
  output logic [TAG_W-1:0] arr_tag,
  output logic [LEN_W-1:0] arr_len
);
  // Stage s holds the READ that was on the command bus s cycles ago
  logic [DEPTH:1]            vld_q, vld_d;
  logic [DEPTH:1][TAG_W-1:0] tag_q, tag_d;
  logic [DEPTH:1][LEN_W-1:0] len_q, len_d;
  logic [DEPTH:0]            vld_a;
  logic [DEPTH:0][TAG_W-1:0] tag_a;
  logic [DEPTH:0][LEN_W-1:0] len_a;

  assign vld_a = {vld_q, in_vld};
  assign tag_a = {tag_q, in_tag};
  assign len_a = {len_q, in_len};

  always_comb begin
    for (int s = 1; s <= DEPTH; s++) begin
      vld_d[s] = vld_a[s-1];
      tag_d[s] = tag_a[s-1];
      len_d[s] = len_a[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      tag_q <= '0;
      len_q <= '0;
    end else begin
      vld_q <= vld_d;
      tag_q <= tag_d;
      len_q <= len_d;
    end
  end

  // Tap chosen by the programmed latency
  always_comb begin
    arr_vld = 1'b0;
    arr_tag = '0;
    arr_len = '0;
    for (int s = 1; s <= DEPTH; s++) begin
      if (sel == CL_W'(s)) begin
        arr_vld = vld_a[s];
        arr_tag = tag_a[s];
        arr_len = len_a[s];
      end
    end
  end
endmodule

// File: rtl/rbs_beat_track.sv
module rbs_beat_track #(
  parameter int DATA_W = 8,
  parameter int TAG_W  = 4,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arr_vld,
  input  logic [TAG_W-1:0]  arr_tag,
  input  logic [LEN_W-1:0]  arr_len,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LEN_W-1:0]  rd_beat
);
  logic [LEN_W-1:0] last_q, last_d;
  logic             vld_d;
  logic [TAG_W-1:0] tag_d;
  logic [LEN_W-1:0] beat_d;
  logic             more;

  assign more = rd_valid && (rd_beat != last_q);

  // A newly arriving burst takes priority and cuts the older one off
  always_comb begin
    vld_d  = 1'b0;
    tag_d  = rd_tag;
    beat_d = rd_beat;
    last_d = last_q;
    if (arr_vld) begin
      vld_d  = 1'b1;
      tag_d  = arr_tag;
      beat_d = '0;
      last_d = arr_len;
    end else if (more) begin
      vld_d  = 1'b1;
      beat_d = rd_beat + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_tag   <= '0;
      rd_beat  <= '0;
      last_q   <= '0;
    end else begin
      rd_valid <= vld_d;
      rd_tag   <= tag_d;
      rd_beat  <= beat_d;
      last_q   <= last_d;
      if (vld_d)
        rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/rd_burst_sched.sv
module rd_burst_sched
  import rbs_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int DATA_W = 8,
  parameter int TAG_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RBS_CL_W-1:0]  cas_lat,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [COL_W-1:0]     req_col,
  input  logic [TAG_W-1:0]     req_tag,
  input  logic [RBS_LEN_W-1:0] req_len,
  output logic                 mem_cs_n,
  output logic                 mem_ras_n,
  output logic                 mem_cas_n,
  output logic                 mem_we_n,
  output logic [BANK_W-1:0]    mem_bank,
  output logic [COL_W-1:0]     mem_addr,
  output logic                 mem_dqm,
  input  logic [DATA_W-1:0]    dq_in,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data,
  output logic [TAG_W-1:0]     rd_tag,
  output logic [RBS_LEN_W-1:0] rd_beat
);
  localparam int LEN_W = RBS_LEN_W;
  localparam int CL_W  = RBS_CL_W;

  rbs_cmd_e         cmd_bus;
  logic             new_vld;
  logic [TAG_W-1:0] new_tag;
  logic [LEN_W-1:0] new_len;
  logic             arr_vld;
  logic [TAG_W-1:0] arr_tag;
  logic [LEN_W-1:0] arr_len;

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_bus;
  assign mem_dqm = 1'b0;

  rbs_issue #(.BANK_W(BANK_W), .COL_W(COL_W), .TAG_W(TAG_W), .LEN_W(LEN_W)) u_issue (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_bank(req_bank), .req_col(req_col),
    .req_tag(req_tag), .req_len(req_len), .req_ready(req_ready),
    .cmd_q(cmd_bus), .bank_q(mem_bank), .col_q(mem_addr),
    .new_vld(new_vld), .new_tag(new_tag), .new_len(new_len)
  );

  rbs_lat_pipe #(.TAG_W(TAG_W), .LEN_W(LEN_W), .DEPTH(RBS_MAX_CL), .CL_W(CL_W)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_vld(new_vld), .in_tag(new_tag), .in_len(new_len), .sel(cas_lat),
    .arr_vld(arr_vld), .arr_tag(arr_tag), .arr_len(arr_len)
  );

  rbs_beat_track #(.DATA_W(DATA_W), .TAG_W(TAG_W), .LEN_W(LEN_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .arr_vld(arr_vld), .arr_tag(arr_tag), .arr_len(arr_len), .dq_in(dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_tag(rd_tag), .rd_beat(rd_beat)
  );
endmodule

// File: rtl/rbs_chk.sv
module rbs_chk #(
  parameter int TAG_W = 4,
  parameter int LEN_W = 2,
  parameter int CL_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CL_W-1:0]  cas_lat,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LEN_W-1:0] req_len,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             rd_valid,
  input logic [TAG_W-1:0] rd_tag,
  input logic [LEN_W-1:0] rd_beat
);
  logic       is_read;
  logic [3:0] hist;
  logic [2:0] idle_cnt;

  assign is_read = ({cs_n, ras_n, cas_n, we_n} == 4'b0101);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist     <= '0;
      idle_cnt <= 3'd7;
    end else begin
      hist <= {hist[2:0], is_read};
      if (is_read)
        idle_cnt <= 3'd0;
      else if (idle_cnt != 3'd7)
        idle_cnt <= idle_cnt + 3'd1;
    end
  end

  // R2
  read_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_read |-> $past(req_valid && req_ready));

  // R3
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len != '0) |=> !req_ready);

  // R3
  single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len == '0) |=> req_ready);

  // R4
  first_beat_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_beat == '0) |-> hist[cas_lat]);

  // R5
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_beat != '0) |->
      ($past(rd_valid) && rd_beat == LEN_W'($past(rd_beat) + 1'b1) && rd_tag == $past(rd_tag)));

  // R8
  cl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_read || idle_cnt != 3'd7) |=> $stable(cas_lat));

  // R8
  cl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_lat != '0);
endmodule

bind rd_burst_sched rbs_chk #(.TAG_W(TAG_W), .LEN_W(LEN_W), .CL_W(CL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat),
  .req_valid(req_valid), .req_ready(req_ready), .req_len(req_len),
  .cs_n(mem_cs_n), .ras_n(mem_ras_n), .cas_n(mem_cas_n), .we_n(mem_we_n),
  .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_beat(rd_beat)
);

// File: tb/sim_rd_burst_sched.sv
module sim_rd_burst_sched;
  // Vector: cl[17:16] bank[15:14] col[13:6] len[5:4] tag[3:0]
  localparam logic [17:0] VEC [0:11] = '{
    {2'd1, 2'd0, 8'h10, 2'd3, 4'd1}, {2'd1, 2'd1, 8'h20, 2'd0, 4'd2},
    {2'd1, 2'd1, 8'h21, 2'd0, 4'd3}, {2'd1, 2'd2, 8'h30, 2'd1, 4'd4},
    {2'd2, 2'd3, 8'h40, 2'd3, 4'd5}, {2'd2, 2'd0, 8'h50, 2'd2, 4'd6},
    {2'd2, 2'd0, 8'h51, 2'd0, 4'd7}, {2'd2, 2'd1, 8'h60, 2'd3, 4'd8},
    {2'd3, 2'd2, 8'h70, 2'd0, 4'd9}, {2'd3, 2'd3, 8'h80, 2'd3, 4'd10},
    {2'd3, 2'd1, 8'h90, 2'd1, 4'd11}, {2'd3, 2'd0, 8'hA0, 2'd3, 4'd12}
  };

  logic       clk, rst_n;
  logic [1:0] cas_lat, req_bank, req_len, mem_bank, rd_beat;
  logic       req_valid, req_ready, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_dqm, rd_valid;
  logic [7:0] req_col, mem_addr, dq_in, rd_data;
  logic [3:0] req_tag, rd_tag, cmd;

  int checks = 0, failures = 0, cyc = 0, wp = 0, rp = 0, cl_cfg = 1, slot = 0, cnt = 0;
  bit got;
  bit exp_rd;
  logic [1:0] exp_b;
  logic [7:0] exp_c;
  logic [7:0] e_data [0:255];
  logic [3:0] e_tag [0:255];
  logic [1:0] e_beat [0:255];
  int         e_cyc [0:255];
  logic [7:0] m_data [0:63];
  bit         m_vld [0:63];

  assign cmd = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};

  rd_burst_sched u0 (
    .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
    .req_col(req_col), .req_tag(req_tag), .req_len(req_len),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_bank(mem_bank), .mem_addr(mem_addr), .mem_dqm(mem_dqm), .dq_in(dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_tag(rd_tag), .rd_beat(rd_beat)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] mem_word(input logic [1:0] b, input logic [7:0] c, input int k);
    return (c + 8'(k)) ^ {b, 6'd0};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Memory model, command check and output monitor, all at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_rd) begin
        chk(cmd == 4'b0101, "R2 READ code", int'(cmd), 5);
        chk(mem_bank == exp_b && mem_addr == exp_c, "R2 bank/col", int'({mem_bank, mem_addr}), int'({exp_b, exp_c}));
      end else
        chk(cmd == 4'b0111, "R2 NOP code", int'(cmd), 7);
      chk(mem_dqm == 1'b0, "R7 dqm", int'(mem_dqm), 0);
      if (cmd == 4'b0101)
        for (int k = 0; k < 4; k++) begin
          slot = (cyc + cl_cfg + k) % 64;
          m_data[slot] = mem_word(mem_bank, mem_addr, k);
          m_vld[slot] = 1'b1;
        end
      slot = cyc % 64;
      dq_in = m_vld[slot] ? m_data[slot] : 8'hEE;
      m_vld[slot] = 1'b0;
      if (rd_valid) begin
        if (rp == wp)
          chk(1'b0, "R5 word past wanted length", int'(rd_beat), 0);
        else begin
          chk(e_cyc[rp % 256] == cyc, "R4 R6 R8 arrival cycle", cyc, e_cyc[rp % 256]);
          chk(rd_data == e_data[rp % 256], "R4 data", int'(rd_data), int'(e_data[rp % 256]));
          chk(rd_tag == e_tag[rp % 256] && rd_beat == e_beat[rp % 256], "R5 tag/beat",
              int'({rd_tag, rd_beat}), int'({e_tag[rp % 256], e_beat[rp % 256]}));
          rp++;
        end
      end else if (rp != wp && e_cyc[rp % 256] == cyc)
        chk(1'b0, "R6 gap in stream", 0, 1);
      exp_rd = req_valid && req_ready;
      if (exp_rd) begin
        exp_b = req_bank;
        exp_c = req_col;
        for (int k = 0; k <= int'(req_len); k++) begin
          e_data[wp % 256] = mem_word(req_bank, req_col, k);
          e_tag[wp % 256]  = req_tag;
          e_beat[wp % 256] = 2'(k);
          e_cyc[wp % 256]  = cyc + cl_cfg + 2 + k;
          wp++;
        end
      end
    end
  end

  task automatic wait_fire();
    do begin
      @(negedge clk);
      got = req_ready;
      @(posedge clk);
      #2;
    end while (!got);
  endtask

  task automatic drain();
    req_valid = 1'b0;
    while (rp != wp) @(posedge clk);
    repeat (6) @(posedge clk);
    #2;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_bank = '0; req_col = '0; req_tag = '0;
    req_len = '0; cas_lat = 2'd1; dq_in = '0; exp_rd = 1'b0;
    for (int i = 0; i < 64; i++) m_vld[i] = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(cmd == 4'b0111, "R1 NOP in reset", int'(cmd), 7);
    chk(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    chk(rd_valid == 1'b0, "R1 no data in reset", int'(rd_valid), 0);
    chk(mem_dqm == 1'b0, "R7 dqm in reset", int'(mem_dqm), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd == 4'b0111 && req_ready && !rd_valid, "R1 after release", int'({cmd, req_ready, rd_valid}), 'h1e);
    @(posedge clk);
    #2;

    // Table walk: back-to-back requests, one group per latency (R6, R8)
    for (int i = 0; i < 12; i++) begin
      if (int'(VEC[i][17:16]) != cl_cfg) begin
        drain();
        cas_lat = VEC[i][17:16];
        cl_cfg = int'(VEC[i][17:16]);
      end
      req_valid = 1'b1;
      req_bank = VEC[i][15:14];
      req_col = VEC[i][13:6];
      req_len = VEC[i][5:4];
      req_tag = VEC[i][3:0];
      wait_fire();
    end
    drain();

    // R3 ready pulse after a three-word request
    req_valid = 1'b1; req_bank = 2'd2; req_col = 8'hC0; req_len = 2'd2; req_tag = 4'd13;
    wait_fire();
    req_valid = 1'b0;
    @(negedge clk); chk(!req_ready, "R3 ready low 1st", int'(req_ready), 0);
    @(negedge clk); chk(!req_ready, "R3 ready low 2nd", int'(req_ready), 0);
    @(negedge clk); chk(req_ready, "R3 ready back", int'(req_ready), 1);
    @(posedge clk); #2;
    drain();

    // R3 single-word reads every cycle, same bank
    for (int i = 0; i < 3; i++) begin
      req_valid = 1'b1; req_bank = 2'd1; req_col = 8'(8'hD0 + i); req_len = 2'd0; req_tag = 4'(14 + i);
      @(negedge clk);
      chk(req_ready, "R3 back-to-back single reads", int'(req_ready), 1);
      @(posedge clk); #2;
    end
    drain();

    // R5 truncated request followed by idle bus
    req_valid = 1'b1; req_bank = 2'd3; req_col = 8'hE0; req_len = 2'd0; req_tag = 4'd1;
    wait_fire();
    drain();
    cnt = 0;
    repeat (8) begin
      @(negedge clk);
      if (rd_valid) cnt++;
    end
    chk(cnt == 0, "R5 no words after truncation", cnt, 0);
    chk(rp == wp, "R6 all expected words seen", rp, wp);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule